// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit sits beside the serial engine of an SPI controller and owns the two byte-wide FIFOs, the interrupt status word, the interrupt enable word and the single interrupt line. Software reaches it through a small register bus addressed by 32-bit word index. Bytes written to the transmit data word enter the TX FIFO, and the serial engine drains them one at a time. Bytes that the serial engine receives are pushed into the RX FIFO, and software pops them by reading the receive data word.

The status word mixes two kinds of bits. Level flags are derived from the occupancy of each FIFO: ready, empty, full, and quarter, half and three-quarter thresholds. Sticky flags record events: overflow and underrun on either FIFO, transfer complete and a slave-select event. Sticky flags stay set until software writes a one to them. Each FIFO can be flushed by an event input. While the controller enable bit is clear, the unit ignores every register write except a write to the control word.

Top module: `spiirq_unit`

## Requirements
- R1: The RX level flags in the status word follow the RX used count u, with depth D (64 by default). Bit 0 is u != 0. Bit 3 is u >= D/4. Bit 1 is u >= D/2. Bit 4 is (D - u) <= D/4. Bit 2 is u == D.
- R2: The TX level flags in the status word follow the TX used count t. Bit 8 is t == 0. Bit 11 is (D - t) >= D/4. Bit 9 is (D - t) >= D/2. Bit 12 is t <= D/4. Bit 10 is t == D.
- R3: Sticky flags are set as follows. Bit 5 is set by an RX push while the RX FIFO is full. Bit 6 is set by a read of the receive data word while the RX FIFO is empty. Bit 13 is set by an enabled write to the transmit data word while the TX FIFO is full. Bit 14 is set by a TX pop while the TX FIFO is empty. Bit 16 is set by the transfer-done pulse, and bit 17 by the slave-select event pulse. Each sticky flag stays set until it is cleared.
- R4: An enabled write to the status word (index 4) clears each sticky bit written as 1. The clear applies within mask 0x80037F7F, and bit 31 is excluded from clearing. Level flags are recomputed from the counts and are not changed by the write.
- R5: The irq output is high exactly when (status AND enable word) is non-zero. The enable word is at index 3, has writable mask 0x37F7F and resets to 0.
- R6: After reset, the status word reads 0x00001B00, the enable word reads 0, both counts are 0, the control word (index 2) reads 0 and irq is low.
- R7: A txFlush pulse empties the TX FIFO and clears bits 13 and 14. An rxFlush pulse empties the RX FIFO and clears bits 5 and 6.
- R8: The count word (index 5) holds the TX used count in bits 22:16 and the RX used count in bits 6:0. All other bits read 0.
- R9: A read of the receive data word (index 0) returns the oldest RX byte, zero-extended, and pops it. On an empty RX FIFO the read returns 0xDEADBEEF.
- R10: A read of the transmit data word (index 1) returns 0. A write to it while the TX FIFO is full is discarded. txHead presents the oldest TX byte, and txPop removes it in FIFO order.
- R11: While control bit 0 (enable) is clear, writes to indices 1, 3 and 4 have no effect. Writes to the control word always take effect.
- R12: Flags and counts reflect a push, pop or flush in the cycle after the event. Read data is combinational in the cycle of the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; a read may pop the RX FIFO |
| regAddr | input | 3 | Word index of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the cycle of regRdEn |
| txPop | input | 1 | Serial engine takes the TX head byte |
| txHead | output | 8 | Oldest TX byte |
| rxPush | input | 1 | Serial engine delivers a received byte |
| rxByte | input | 8 | Received byte |
| txFlush | input | 1 | Flush the TX FIFO |
| rxFlush | input | 1 | Flush the RX FIFO |
| xferDone | input | 1 | Transfer complete event |
| ssEvent | input | 1 | Slave-select event |
| irq | output | 1 | Interrupt line |

## Verification
A wrong occupancy count shows up in the cycle after the event: in the count word, and in the threshold pattern of the status word. This is why the bench walks each FIFO through every threshold boundary and one step past it. A lost or duplicated byte is caught at the next data read or txHead sample by the byte scoreboards. A sticky flag that clears wrongly, or that fails to hold, shows at the irq pin one cycle after the enable word is set. A missing write gate shows as a changed enable word or status word when read back after the controller is re-enabled.

// File: rtl/spiirq_pkg.sv
package spiirq_pkg;

  localparam logic [2:0] IDX_RXD = 3'd0;
  localparam logic [2:0] IDX_TXD = 3'd1;
  localparam logic [2:0] IDX_CTL = 3'd2;
  localparam logic [2:0] IDX_IEN = 3'd3;
  localparam logic [2:0] IDX_STS = 3'd4;
  localparam logic [2:0] IDX_CNT = 3'd5;

  localparam logic [31:0] IEN_MASK   = 32'h0003_7F7F;
  localparam logic [31:0] CLR_MASK   = 32'h8003_7F7F;
  localparam logic [31:0] PROT_BIT   = 32'h8000_0000;
  localparam logic [31:0] EMPTY_READ = 32'hDEAD_BEEF;

  localparam int B_RX_RDY  = 0;
  localparam int B_RX_HALF = 1;
  localparam int B_RX_FULL = 2;
  localparam int B_RX_QTR  = 3;
  localparam int B_RX_3QTR = 4;
  localparam int B_RX_OVF  = 5;
  localparam int B_RX_UND  = 6;
  localparam int B_TX_EMP  = 8;
  localparam int B_TX_HALF = 9;
  localparam int B_TX_FULL = 10;
  localparam int B_TX_QTR  = 11;
  localparam int B_TX_3QTR = 12;
  localparam int B_TX_OVF  = 13;
  localparam int B_TX_UND  = 14;
  localparam int B_DONE    = 16;
  localparam int B_SS      = 17;

  typedef struct packed {
    logic txWrite;
    logic rxRead;
    logic ienWrite;
    logic stsClear;
  } dpStrobe_t;

endpackage

// File: rtl/spiirq_fifo.sv
module spiirq_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] pushData,
  input  logic          pop,
  output logic [DW-1:0] headData,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] rdPtr, wrPtr;
  logic          pushOk, popOk;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign pushOk = push && !full;
  assign popOk  = pop && !empty;
  assign headData = mem[rdPtr];

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (pushOk && !clr) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (clr) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk)  rdPtr <= nextPtr(rdPtr);
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/spiirq_ctrl.sv
module spiirq_ctrl
  import spiirq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      regWrEn,
  input  logic      regRdEn,
  input  logic [2:0] regAddr,
  input  logic      enBitIn,
  output logic      ctlEn,
  output dpStrobe_t strobes
);

  logic gatedWr;

  assign gatedWr = regWrEn && ctlEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              ctlEn <= 1'b0;
    else if (regWrEn && regAddr == IDX_CTL) ctlEn <= enBitIn;
  end

  always_comb begin
    strobes          = '0;
    strobes.txWrite  = gatedWr && (regAddr == IDX_TXD);
    strobes.ienWrite = gatedWr && (regAddr == IDX_IEN);
    strobes.stsClear = gatedWr && (regAddr == IDX_STS);
    strobes.rxRead   = regRdEn && (regAddr == IDX_RXD);
  end

endmodule

// File: rtl/spiirq_datapath.sv
module spiirq_datapath
  import spiirq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int Q1   = DEPTH / 4,
  localparam int Q2   = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobes,
  input  logic          ctlEn,
  input  logic [2:0]    regAddr,
  input  logic [31:0]   regWdata,
  output logic [31:0]   regRdata,
  input  logic          txPop,
  output logic [7:0]    txHead,
  input  logic          rxPush,
  input  logic [7:0]    rxByte,
  input  logic          txFlush,
  input  logic          rxFlush,
  input  logic          xferDone,
  input  logic          ssEvent,
  output logic          irq,
  output logic [CW-1:0] txCount,
  output logic [CW-1:0] rxCount,
  output logic [31:0]   ienQ
);

  logic          txFull, txEmpty, rxFull, rxEmpty;
  logic [7:0]    rxHead;
  logic [CW-1:0] txFree, rxFree;
  logic [31:0]   clrVec, sts;
  logic          rxOvf, rxUnd, txOvf, txUnd, doneQ, ssQ;

  spiirq_fifo #(.DEPTH(DEPTH), .DW(8)) uTxFifo (
    .clk(clk), .rstN(rstN), .clr(txFlush),
    .push(strobes.txWrite), .pushData(regWdata[7:0]),
    .pop(txPop), .headData(txHead),
    .count(txCount), .full(txFull), .empty(txEmpty)
  );

  spiirq_fifo #(.DEPTH(DEPTH), .DW(8)) uRxFifo (
    .clk(clk), .rstN(rstN), .clr(rxFlush),
    .push(rxPush), .pushData(rxByte),
    .pop(strobes.rxRead), .headData(rxHead),
    .count(rxCount), .full(rxFull), .empty(rxEmpty)
  );

  assign txFree = CW'(DEPTH) - txCount;
  assign rxFree = CW'(DEPTH) - rxCount;
  assign clrVec = strobes.stsClear ? (regWdata & CLR_MASK & ~PROT_BIT) : '0;

  // event flags: set wins over a same-cycle clear, flush wins over both
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxOvf <= 1'b0; rxUnd <= 1'b0;
      txOvf <= 1'b0; txUnd <= 1'b0;
      doneQ <= 1'b0; ssQ   <= 1'b0;
    end else begin
      if (rxFlush) begin
        rxOvf <= 1'b0;
        rxUnd <= 1'b0;
      end else begin
        rxOvf <= (rxPush && rxFull) || (rxOvf && !clrVec[B_RX_OVF]);
        rxUnd <= (strobes.rxRead && rxEmpty) || (rxUnd && !clrVec[B_RX_UND]);
      end
      if (txFlush) begin
        txOvf <= 1'b0;
        txUnd <= 1'b0;
      end else begin
        txOvf <= (strobes.txWrite && txFull) || (txOvf && !clrVec[B_TX_OVF]);
        txUnd <= (txPop && txEmpty) || (txUnd && !clrVec[B_TX_UND]);
      end
      doneQ <= xferDone || (doneQ && !clrVec[B_DONE]);
      ssQ   <= ssEvent  || (ssQ   && !clrVec[B_SS]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 ienQ <= '0;
    else if (strobes.ienWrite) ienQ <= regWdata & IEN_MASK;
  end

  always_comb begin
    sts             = '0;
    sts[B_RX_RDY]   = !rxEmpty;
    sts[B_RX_QTR]   = rxCount >= CW'(Q1);
    sts[B_RX_HALF]  = rxCount >= CW'(Q2);
    sts[B_RX_3QTR]  = rxFree <= CW'(Q1);
    sts[B_RX_FULL]  = rxFull;
    sts[B_RX_OVF]   = rxOvf;
    sts[B_RX_UND]   = rxUnd;
    sts[B_TX_EMP]   = txEmpty;
    sts[B_TX_QTR]   = txFree >= CW'(Q1);
    sts[B_TX_HALF]  = txFree >= CW'(Q2);
    sts[B_TX_3QTR]  = txCount <= CW'(Q1);
    sts[B_TX_FULL]  = txFull;
    sts[B_TX_OVF]   = txOvf;
    sts[B_TX_UND]   = txUnd;
    sts[B_DONE]     = doneQ;
    sts[B_SS]       = ssQ;
  end

  assign irq = |(sts & ienQ);

  always_comb begin
    case (regAddr)
      IDX_RXD: regRdata = rxEmpty ? EMPTY_READ : {24'd0, rxHead};
      IDX_TXD: regRdata = '0;
      IDX_CTL: regRdata = {31'd0, ctlEn};
      IDX_IEN: regRdata = ienQ;
      IDX_STS: regRdata = sts;
      IDX_CNT: regRdata = {9'd0, 7'(txCount), 9'd0, 7'(rxCount)};
      default: regRdata = '0;
    endcase
  end

endmodule

// File: rtl/spiirq_unit.sv
module spiirq_unit
  import spiirq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        txPop,
  output logic [7:0]  txHead,
  input  logic        rxPush,
  input  logic [7:0]  rxByte,
  input  logic        txFlush,
  input  logic        rxFlush,
  input  logic        xferDone,
  input  logic        ssEvent,
  output logic        irq
);

  dpStrobe_t     strobes;
  logic          ctlEn;
  logic [CW-1:0] txCount, rxCount;
  logic [31:0]   ienQ;

  spiirq_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .enBitIn(regWdata[0]), .ctlEn(ctlEn), .strobes(strobes)
  );

  spiirq_datapath #(.DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ctlEn(ctlEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .txPop(txPop), .txHead(txHead), .rxPush(rxPush), .rxByte(rxByte),
    .txFlush(txFlush), .rxFlush(rxFlush),
    .xferDone(xferDone), .ssEvent(ssEvent), .irq(irq),
    .txCount(txCount), .rxCount(rxCount), .ienQ(ienQ)
  );

endmodule

// File: rtl/spiirq_unit_chk.sv
module spiirq_unit_chk
  import spiirq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          regWrEn,
  input logic          regRdEn,
  input logic [2:0]    regAddr,
  input logic [31:0]   regRdata,
  input logic          txPop,
  input logic          txFlush,
  input logic          rxFlush,
  input logic          irq,
  input logic          ctlEn,
  input logic [CW-1:0] txCount,
  input logic [CW-1:0] rxCount,
  input logic [31:0]   ienQ
);

  a_r12_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= CW'(DEPTH)) && (rxCount <= CW'(DEPTH)));

  a_r10_full_write_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && ctlEn && regAddr == IDX_TXD && txCount == CW'(DEPTH) && !txPop && !txFlush)
      |=> (txCount == CW'(DEPTH)));

  a_r9_empty_read_value: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == IDX_RXD && rxCount == '0) |-> (regRdata == EMPTY_READ));

  a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (ienQ == '0) |-> !irq);

  a_r11_disabled_ien_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlEn && regWrEn && regAddr == IDX_IEN) |=> $stable(ienQ));

  a_r7_tx_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    txFlush |=> (txCount == '0));

  a_r7_rx_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    rxFlush |=> (rxCount == '0));

endmodule

bind spiirq_unit spiirq_unit_chk #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .regRdata(regRdata), .txPop(txPop),
  .txFlush(txFlush), .rxFlush(rxFlush), .irq(irq), .ctlEn(ctlEn),
  .txCount(txCount), .rxCount(rxCount), .ienQ(ienQ)
);

// File: tb/tb_spiirq_unit.sv
`timescale 1ns/100ps
module tb_spiirq_unit;

  localparam int D = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        txPop = 1'b0, rxPush = 1'b0;
  logic [7:0]  txHead;
  logic [7:0]  rxByte = '0;
  logic        txFlush = 1'b0, rxFlush = 1'b0, xferDone = 1'b0, ssEvent = 1'b0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [7:0] rxExp[$];
  logic [7:0] txExp[$];
  int rxModel = 0;
  int txModel = 0;

  always #2.5 clk = ~clk;

  spiirq_unit #(.DEPTH(D)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .txPop(txPop), .txHead(txHead), .rxPush(rxPush), .rxByte(rxByte),
    .txFlush(txFlush), .rxFlush(rxFlush), .xferDone(xferDone),
    .ssEvent(ssEvent), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  // driver: records each accepted RX byte in the scoreboard
  task automatic drvRx(input logic [7:0] b);
    @(negedge clk);
    rxPush = 1'b1; rxByte = b;
    if (rxModel < D) begin
      rxExp.push_back(b);
      rxModel++;
    end
    @(negedge clk);
    rxPush = 1'b0;
  endtask

  // monitor side: compare a popped RX byte with the scoreboard head
  task automatic monRx();
    logic [31:0] v;
    logic [7:0]  e;
    busRd(3'd0, v);
    if (rxExp.size() == 0) begin
      chk("R9 empty read", v, 32'hDEAD_BEEF);
    end else begin
      e = rxExp.pop_front();
      rxModel--;
      chk("R9 rx order", v, {24'd0, e});
    end
  endtask

  task automatic drvTx(input logic [7:0] b);
    busWr(3'd1, {24'hABCDEF, b});
    if (txModel < D) begin
      txExp.push_back(b);
      txModel++;
    end
  endtask

  task automatic monTx();
    @(negedge clk);
    #1;
    if (txExp.size() != 0) begin
      chk("R10 tx head order", {24'd0, txHead}, {24'd0, txExp.pop_front()});
      txModel--;
    end
    txPop = 1'b1;
    @(negedge clk);
    txPop = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: xferDone = 1'b1;
      1: ssEvent  = 1'b1;
      2: begin txFlush = 1'b1; rxFlush = 1'b1; end
      default: ;
    endcase
    @(negedge clk);
    xferDone = 1'b0; ssEvent = 1'b0; txFlush = 1'b0; rxFlush = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R6 reset state
    busRd(3'd4, v); chk("R6 status reset", v, 32'h0000_1B00);
    busRd(3'd3, v); chk("R6 enable reset", v, 32'h0);
    busRd(3'd5, v); chk("R6 counts reset", v, 32'h0);
    busRd(3'd2, v); chk("R6 control reset", v, 32'h0);
    chk("R6 irq low", {31'd0, irq}, 32'h0);

    // R11 writes ignored while disabled
    busWr(3'd3, 32'hFFFF_FFFF);
    busWr(3'd1, 32'h55);
    busRd(3'd3, v); chk("R11 enable word unchanged", v, 32'h0);
    busRd(3'd5, v); chk("R11 tx write ignored", v, 32'h0);
    busWr(3'd2, 32'h1);
    busRd(3'd2, v); chk("R11 control write accepted", v, 32'h1);

    // R12 first push visible only after the edge
    @(negedge clk);
    rxPush = 1'b1; rxByte = 8'h10; regRdEn = 1'b1; regAddr = 3'd4;
    rxExp.push_back(8'h10); rxModel++;
    #1 chk("R12 flag before edge", regRdata & 32'h7F, 32'h0);
    @(negedge clk);
    rxPush = 1'b0;
    #1 chk("R12 flag after edge", regRdata & 32'h7F, 32'h1);
    @(negedge clk);
    regRdEn = 1'b0;

    // R1 RX thresholds
    for (int i = 1; i < 16; i++) drvRx(8'(i * 3 + 1));
    busRd(3'd4, v); chk("R1 rx quarter", v & 32'h7F, 32'h09);
    for (int i = 16; i < 32; i++) drvRx(8'(i * 3 + 1));
    busRd(3'd4, v); chk("R1 rx half", v & 32'h7F, 32'h0B);
    for (int i = 32; i < 48; i++) drvRx(8'(i * 3 + 1));
    busRd(3'd4, v); chk("R1 rx three-quarter", v & 32'h7F, 32'h1B);
    for (int i = 48; i < 64; i++) drvRx(8'(i * 3 + 1));
    busRd(3'd4, v); chk("R1 rx full", v & 32'h7F, 32'h1F);
    drvRx(8'hEE);
    busRd(3'd4, v); chk("R3 rx overflow", v & 32'h7F, 32'h3F);
    busRd(3'd5, v); chk("R8 rx count field", v, 32'h0000_0040);

    // R9 drain through the scoreboard
    for (int i = 0; i < 64; i++) monRx();
    monRx();
    busRd(3'd4, v); chk("R3 rx underrun", v & 32'h7F, 32'h60);

    // R4 clear everything; level flags stay
    busWr(3'd4, 32'hFFFF_FFFF);
    busRd(3'd4, v); chk("R4 clear keeps level flags", v, 32'h0000_1B00);

    // R2 TX thresholds
    for (int i = 0; i < 16; i++) drvTx(8'(i + 8'hA0));
    busRd(3'd4, v); chk("R2 tx used 16", v & 32'h7F00, 32'h1A00);
    drvTx(8'h5A);
    busRd(3'd4, v); chk("R2 tx used 17", v & 32'h7F00, 32'h0A00);
    for (int i = 17; i < 33; i++) drvTx(8'(i * 5));
    busRd(3'd4, v); chk("R2 tx used 33", v & 32'h7F00, 32'h0800);
    for (int i = 33; i < 49; i++) drvTx(8'(i * 5));
    busRd(3'd4, v); chk("R2 tx used 49", v & 32'h7F00, 32'h0000);
    for (int i = 49; i < 64; i++) drvTx(8'(i * 5));
    busRd(3'd4, v); chk("R2 tx full", v & 32'h7F00, 32'h0400);
    drvTx(8'hFF);
    busRd(3'd4, v); chk("R10 full write dropped, R3 tx overflow", v & 32'h7F00, 32'h2400);
    busRd(3'd5, v); chk("R8 tx count field", v, 32'h0040_0000);

    for (int i = 0; i < 64; i++) monTx();
    busWr(3'd4, 32'h2000);
    monTx();
    busRd(3'd4, v); chk("R3 tx underrun", v, 32'h0000_5B00);
    busRd(3'd1, v); chk("R10 tx data reads zero", v, 32'h0);

    // R5 interrupt line
    busWr(3'd3, 32'h4000);
    #1 chk("R5 irq on enabled underrun", {31'd0, irq}, 32'h1);
    busWr(3'd4, 32'h4000);
    #1 chk("R5 irq drops after clear", {31'd0, irq}, 32'h0);
    busWr(3'd3, 32'h1_0000);
    pulse(0);
    #1 chk("R5 irq on transfer done", {31'd0, irq}, 32'h1);
    busWr(3'd4, 32'h1_0000);
    busWr(3'd3, 32'h2_0000);
    pulse(1);
    #1 chk("R5 irq on ss event", {31'd0, irq}, 32'h1);
    busWr(3'd4, 32'h2_0000);
    #1 chk("R4 ss cleared", {31'd0, irq}, 32'h0);
    busWr(3'd3, 32'h0);

    // R7 flush
    for (int i = 0; i < 5; i++) drvRx(8'(i));
    drvTx(8'h11); drvTx(8'h22);
    busRd(3'd5, v); chk("R8 both counts", v, 32'h0002_0005);
    monTx(); monTx(); monTx();
    drvTx(8'h33);
    pulse(2);
    rxExp.delete(); txExp.delete(); rxModel = 0; txModel = 0;
    busRd(3'd4, v); chk("R7 flush status", v, 32'h0000_1B00);
    busRd(3'd5, v); chk("R7 flush counts", v, 32'h0);

    // R11 status clear and tx write ignored while disabled
    pulse(0);
    busWr(3'd2, 32'h0);
    busWr(3'd4, 32'h1_0000);
    busWr(3'd1, 32'h77);
    busWr(3'd3, 32'h1_0000);
    busWr(3'd2, 32'h1);
    busRd(3'd4, v); chk("R11 status clear ignored", v, 32'h0001_1B00);
    busRd(3'd3, v); chk("R11 enable write ignored", v, 32'h0);
    busRd(3'd5, v); chk("R11 tx push ignored", v, 32'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule